// File: doc/BRIEF.md
# Cache-Line Fetch Group Former

This block sits at the front of an instruction pipeline. Every cycle it may be asked to cut a group of instructions out of one instruction-cache line that is already resident. The fetch PC it holds gives the first word. It hands up to `FETCH_W` instructions toward decode, each with its own PC and a sequence number drawn from a counter that never repeats. Pre-decode marks which words are control transfers and which are quiesce instructions. A separate predictor supplies a taken bit and a target for each word.

A group stops at the end of the line, at the width limit, or once a predicted-taken branch and its single delay-slot instruction have both been sent. When the delay slot falls outside the current group, the pending redirect is held over to the next cycle. A quiesce instruction parks the thread until a redirect arrives. An outstanding cache miss stalls fetch and is counted. A redirect (squash) reloads the PC and drops any pending delay slot or parked state. Running counters track fetched instructions, branches, predicted-taken branches and stall cycles.

Top module: `fetch_group_former`

## Requirements
- R1: After reset, `grp_valid`, `slot_valid`, all slot fields, `quiesce_pending`, `dslot_pending` and all counters read zero, and `fetch_pc` equals `RESET_PC`.
- R2: A fetch starts at word index `fetch_pc[log2(LINE_BYTES)-1:2]` of `line_data`. Word i occupies bits `[32*i+31:32*i]`. Slot k carries word start+k and its PC, and slot k sits at bits `[32*k+31:32*k]` of `slot_insn` and `[AW*k+AW-1:AW*k]` of `slot_pc`. Slots that are not emitted read zero.
- R3: A group ends at the last word of the line or after `FETCH_W` slots, whichever comes first. Unless a branch redirects, `fetch_pc` then advances to 4 past the last emitted PC.
- R4: Emitted slots get consecutive sequence numbers. The first slot after reset gets 0, and numbering continues across groups.
- R5: When a word has `ctl_mask` and `taken_mask` set (predicted taken), the next word is its delay slot. If it lies in the same group it is emitted, the group ends, and `fetch_pc` becomes the branch word's `pred_target` entry (bits `[AW*i+AW-1:AW*i]`). The control and taken bits of a delay-slot word are ignored.
- R6: When a predicted-taken branch is the last word emitted, `dslot_pending` is raised and `fetch_pc` moves to the delay-slot address. The next group then holds exactly that one instruction, and `fetch_pc` becomes the held target.
- R7: `cnt_fetched` adds the group size. `cnt_branch` counts emitted control words that are not delay slots, and `cnt_taken` counts those among them that are predicted taken. A not-taken branch does not end the group.
- R8: A quiesce-marked word is emitted and ends the group, and `quiesce_pending` rises. No group is emitted afterwards until a redirect.
- R9: A fetch request while `miss_pending` is high (and not parked) emits nothing, leaves `fetch_pc` unchanged and increments `cnt_stall`.
- R10: Group outputs are registered and appear one cycle after the request. `grp_valid` is high only when at least one slot is emitted, and `slot_valid` is a contiguous run of ones from slot 0 whose population equals `grp_count`.
- R11: `redir_valid` takes priority over a fetch request in the same cycle. It loads `fetch_pc` from `redir_pc`, clears `dslot_pending` and `quiesce_pending`, and emits nothing.
- R12: With `fetch_req` low and no redirect, nothing is emitted and `fetch_pc`, the counters and the pending flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Squash / redirect request |
| redir_pc | input | AW | New fetch PC on redirect |
| fetch_req | input | 1 | Request a fetch group this cycle |
| miss_pending | input | 1 | Cache miss outstanding for the line |
| line_data | input | 8*LINE_BYTES | Resident line, word i at bits 32*i upward |
| ctl_mask | input | LINE_BYTES/4 | Per-word control-transfer marker |
| taken_mask | input | LINE_BYTES/4 | Per-word predicted-taken bit |
| quiesce_mask | input | LINE_BYTES/4 | Per-word quiesce marker |
| pred_target | input | AW*LINE_BYTES/4 | Per-word predicted target |
| grp_valid | output | 1 | Group written toward decode |
| grp_count | output | clog2(FETCH_W+1) | Number of emitted slots |
| slot_valid | output | FETCH_W | Per-slot valid |
| slot_insn | output | 32*FETCH_W | Per-slot instruction word |
| slot_pc | output | AW*FETCH_W | Per-slot PC |
| slot_seq | output | SEQ_W*FETCH_W | Per-slot sequence number |
| fetch_pc | output | AW | Current fetch PC |
| quiesce_pending | output | 1 | Thread parked by quiesce |
| dslot_pending | output | 1 | Delay slot carried to the next group |
| cnt_fetched | output | CNT_W | Fetched instruction count |
| cnt_branch | output | CNT_W | Fetched branch count |
| cnt_taken | output | CNT_W | Predicted-taken branch count |
| cnt_stall | output | CNT_W | Miss stall cycle count |

## Verification
Every result, including the group slots, `fetch_pc`, the pending flags and all four counters, is registered. Each is therefore due at the first rising edge after the inputs that caused it. The driver applies each stimulus on a falling edge and queues the expected outcome at the same time. The monitor pops that entry on the next falling edge, half a period after the capturing edge, so each comparison lands exactly one cycle after its stimulus. A two-cycle effect, such as a delay slot carried into the next group, is checked as two queued entries, one per request.

// File: rtl/fgf_pkg.sv
package fgf_pkg;
    localparam int INSN_BYTES = 4;
    localparam int INSN_W     = 32;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_PARKED  = 1'b1
    } run_state_e;
endpackage

// File: rtl/fgf_slot_scan.sv
module fgf_slot_scan #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int FETCH_W    = 4,
    parameter int DELAY_SLOT = 1,
    localparam int WORDS     = LINE_BYTES / fgf_pkg::INSN_BYTES,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CW        = $clog2(FETCH_W + 1)
) (
    input  logic [AW-1:0]                          start_pc,
    input  logic                                   dsp_in,
    input  logic [AW-1:0]                          dst_in,
    input  logic [WORDS*fgf_pkg::INSN_W-1:0]       line,
    input  logic [WORDS-1:0]                       ctl,
    input  logic [WORDS-1:0]                       tkn,
    input  logic [WORDS-1:0]                       qui,
    input  logic [WORDS*AW-1:0]                    tgt,
    output logic [FETCH_W-1:0]                     vld,
    output logic [FETCH_W-1:0][AW-1:0]             spc,
    output logic [FETCH_W-1:0][fgf_pkg::INSN_W-1:0] ins,
    output logic [CW-1:0]                          cnt,
    output logic [AW-1:0]                          nxt_pc,
    output logic                                   dsp_out,
    output logic [AW-1:0]                          dst_out,
    output logic                                   q_hit,
    output logic [CW-1:0]                          n_br,
    output logic [CW-1:0]                          n_tk
);
    localparam logic [AW-1:0] STEP = AW'(fgf_pkg::INSN_BYTES);

    logic [AW-1:0] cur_pc;
    logic          stop;
    int            w_idx;

    always_comb begin
        vld     = '0;
        spc     = '0;
        ins     = '0;
        cnt     = '0;
        n_br    = '0;
        n_tk    = '0;
        q_hit   = 1'b0;
        stop    = 1'b0;
        cur_pc  = start_pc;
        dsp_out = dsp_in;
        dst_out = dst_in;
        w_idx   = int'(start_pc[OFF_W-1:2]);
        for (int k = 0; k < FETCH_W; k++) begin
            if (!stop && w_idx < WORDS) begin
                vld[k] = 1'b1;
                spc[k] = cur_pc;
                ins[k] = line[w_idx*fgf_pkg::INSN_W +: fgf_pkg::INSN_W];
                cnt    = cnt + 1'b1;
                if (dsp_out) begin
                    // this word is the delay slot: resolve the held redirect
                    cur_pc  = dst_out;
                    dsp_out = 1'b0;
                    stop    = 1'b1;
                end else if (ctl[w_idx]) begin
                    n_br = n_br + 1'b1;
                    if (tkn[w_idx]) begin
                        n_tk = n_tk + 1'b1;
                        if (DELAY_SLOT != 0) begin
                            dsp_out = 1'b1;
                            dst_out = tgt[w_idx*AW +: AW];
                            cur_pc  = cur_pc + STEP;
                        end else begin
                            cur_pc = tgt[w_idx*AW +: AW];
                            stop   = 1'b1;
                        end
                    end else begin
                        cur_pc = cur_pc + STEP;
                    end
                end else begin
                    cur_pc = cur_pc + STEP;
                end
                if (qui[w_idx]) begin
                    q_hit = 1'b1;
                    stop  = 1'b1;
                end
                w_idx = w_idx + 1;
            end
        end
        nxt_pc = cur_pc;
    end
endmodule

// File: rtl/fgf_stats.sv
module fgf_stats #(
    parameter int CNT_W = 16,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             stall,
    input  logic [CW-1:0]    add_insn,
    input  logic [CW-1:0]    add_br,
    input  logic [CW-1:0]    add_tk,
    output logic [CNT_W-1:0] cnt_fetched,
    output logic [CNT_W-1:0] cnt_branch,
    output logic [CNT_W-1:0] cnt_taken,
    output logic [CNT_W-1:0] cnt_stall
);
    typedef struct packed {
        logic [CNT_W-1:0] fet;
        logic [CNT_W-1:0] br;
        logic [CNT_W-1:0] tk;
        logic [CNT_W-1:0] st;
    } stats_t;

    stats_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fire) begin
            s_d.fet = s_q.fet + CNT_W'(add_insn);
            s_d.br  = s_q.br  + CNT_W'(add_br);
            s_d.tk  = s_q.tk  + CNT_W'(add_tk);
        end
        if (stall) begin
            s_d.st = s_q.st + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_fetched = s_q.fet;
    assign cnt_branch  = s_q.br;
    assign cnt_taken   = s_q.tk;
    assign cnt_stall   = s_q.st;
endmodule

// File: rtl/fetch_group_former.sv
module fetch_group_former #(
    parameter int              AW         = 32,
    parameter int              LINE_BYTES = 32,
    parameter int              FETCH_W    = 4,
    parameter int              SEQ_W      = 16,
    parameter int              CNT_W      = 16,
    parameter int              DELAY_SLOT = 1,
    parameter logic [AW-1:0]   RESET_PC   = '0,
    localparam int             WORDS      = LINE_BYTES / fgf_pkg::INSN_BYTES,
    localparam int             IW         = fgf_pkg::INSN_W,
    localparam int             CW         = $clog2(FETCH_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     redir_valid,
    input  logic [AW-1:0]            redir_pc,
    input  logic                     fetch_req,
    input  logic                     miss_pending,
    input  logic [LINE_BYTES*8-1:0]  line_data,
    input  logic [WORDS-1:0]         ctl_mask,
    input  logic [WORDS-1:0]         taken_mask,
    input  logic [WORDS-1:0]         quiesce_mask,
    input  logic [WORDS*AW-1:0]      pred_target,
    output logic                     grp_valid,
    output logic [CW-1:0]            grp_count,
    output logic [FETCH_W-1:0]       slot_valid,
    output logic [FETCH_W*IW-1:0]    slot_insn,
    output logic [FETCH_W*AW-1:0]    slot_pc,
    output logic [FETCH_W*SEQ_W-1:0] slot_seq,
    output logic [AW-1:0]            fetch_pc,
    output logic                     quiesce_pending,
    output logic                     dslot_pending,
    output logic [CNT_W-1:0]         cnt_fetched,
    output logic [CNT_W-1:0]         cnt_branch,
    output logic [CNT_W-1:0]         cnt_taken,
    output logic [CNT_W-1:0]         cnt_stall
);
    import fgf_pkg::*;

    generate
        if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0 ||
            (LINE_BYTES % INSN_BYTES) != 0) begin : g_bad_line
            $error("fetch_group_former: LINE_BYTES must be a power of two of at least 8");
        end
        if (FETCH_W < 1 || DELAY_SLOT < 0 || DELAY_SLOT > 1) begin : g_bad_cfg
            $error("fetch_group_former: FETCH_W must be >= 1 and DELAY_SLOT 0 or 1");
        end
    endgenerate

    typedef struct packed {
        logic [AW-1:0]                  pc;
        logic [SEQ_W-1:0]               seq;
        logic                           dsp;
        logic [AW-1:0]                  dst;
        run_state_e                     st;
        logic                           gv;
        logic [CW-1:0]                  cnt;
        logic [FETCH_W-1:0]             sv;
        logic [FETCH_W-1:0][IW-1:0]     ins;
        logic [FETCH_W-1:0][AW-1:0]     spc;
        logic [FETCH_W-1:0][SEQ_W-1:0]  sseq;
    } state_t;

    state_t r_d, r_q;

    // slot scan results
    logic [FETCH_W-1:0]          sc_vld;
    logic [FETCH_W-1:0][AW-1:0]  sc_pc;
    logic [FETCH_W-1:0][IW-1:0]  sc_ins;
    logic [CW-1:0]               sc_cnt;
    logic [AW-1:0]               sc_nxt;
    logic                        sc_dsp;
    logic [AW-1:0]               sc_dst;
    logic                        sc_q;
    logic [CW-1:0]               sc_br;
    logic [CW-1:0]               sc_tk;

    fgf_slot_scan #(
        .AW(AW), .LINE_BYTES(LINE_BYTES), .FETCH_W(FETCH_W), .DELAY_SLOT(DELAY_SLOT)
    ) u_scan (
        .start_pc(r_q.pc), .dsp_in(r_q.dsp), .dst_in(r_q.dst),
        .line(line_data), .ctl(ctl_mask), .tkn(taken_mask), .qui(quiesce_mask),
        .tgt(pred_target),
        .vld(sc_vld), .spc(sc_pc), .ins(sc_ins), .cnt(sc_cnt), .nxt_pc(sc_nxt),
        .dsp_out(sc_dsp), .dst_out(sc_dst), .q_hit(sc_q), .n_br(sc_br), .n_tk(sc_tk)
    );

    logic do_fetch;
    logic do_stall;

    always_comb begin
        do_fetch = !redir_valid && fetch_req && r_q.st == ST_RUN && !miss_pending;
        do_stall = !redir_valid && fetch_req && r_q.st == ST_RUN &&  miss_pending;

        r_d      = r_q;
        r_d.gv   = 1'b0;
        r_d.cnt  = '0;
        r_d.sv   = '0;
        r_d.ins  = '0;
        r_d.spc  = '0;
        r_d.sseq = '0;

        if (redir_valid) begin
            r_d.pc  = redir_pc;
            r_d.dsp = 1'b0;
            r_d.dst = '0;
            r_d.st  = ST_RUN;
        end else if (do_fetch) begin
            r_d.pc   = sc_nxt;
            r_d.dsp  = sc_dsp;
            r_d.dst  = sc_dst;
            r_d.gv   = sc_cnt != '0;
            r_d.cnt  = sc_cnt;
            r_d.sv   = sc_vld;
            r_d.ins  = sc_ins;
            r_d.spc  = sc_pc;
            for (int k = 0; k < FETCH_W; k++) begin
                if (sc_vld[k]) r_d.sseq[k] = r_q.seq + SEQ_W'(k);
            end
            r_d.seq  = r_q.seq + SEQ_W'(sc_cnt);
            if (sc_q) r_d.st = ST_PARKED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.pc <= RESET_PC;
            r_q.st <= ST_RUN;
        end else begin
            r_q <= r_d;
        end
    end

    fgf_stats #(.CNT_W(CNT_W), .CW(CW)) u_stats (
        .clk(clk), .rst_n(rst_n), .fire(do_fetch), .stall(do_stall),
        .add_insn(sc_cnt), .add_br(sc_br), .add_tk(sc_tk),
        .cnt_fetched(cnt_fetched), .cnt_branch(cnt_branch),
        .cnt_taken(cnt_taken), .cnt_stall(cnt_stall)
    );

    assign grp_valid       = r_q.gv;
    assign grp_count       = r_q.cnt;
    assign slot_valid      = r_q.sv;
    assign slot_insn       = r_q.ins;
    assign slot_pc         = r_q.spc;
    assign slot_seq        = r_q.sseq;
    assign fetch_pc        = r_q.pc;
    assign quiesce_pending = r_q.st == ST_PARKED;
    assign dslot_pending   = r_q.dsp;

    // ---------------- assertions ----------------
    a_r10_contiguous_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid & FETCH_W'(slot_valid + 1'b1)) == '0);

    a_r10_valid_means_slots: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid == ($countones(slot_valid) != 0));

    a_r9_stall_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && miss_pending && !redir_valid && !quiesce_pending)
        |=> (!grp_valid && cnt_stall == CNT_W'($past(cnt_stall) + 1'b1)
             && $stable(fetch_pc)));

    a_r8_parked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (quiesce_pending && !redir_valid) |=> (!grp_valid && quiesce_pending));

    a_r11_redirect_loads: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (!grp_valid && fetch_pc == $past(redir_pc)
                         && !dslot_pending && !quiesce_pending));

    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_req && !redir_valid) |=> (!grp_valid && $stable(fetch_pc)
                                          && $stable(cnt_fetched)));

    generate
        for (genvar k = 0; k + 1 < FETCH_W; k++) begin : g_slot_chk
            a_r3_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
                slot_valid[k+1] |-> slot_pc[(k+1)*AW +: AW] ==
                                    slot_pc[k*AW +: AW] + AW'(INSN_BYTES));
            a_r4_seq_steps: assert property (@(posedge clk) disable iff (!rst_n)
                slot_valid[k+1] |-> slot_seq[(k+1)*SEQ_W +: SEQ_W] ==
                                    SEQ_W'(slot_seq[k*SEQ_W +: SEQ_W] + 1'b1));
        end
    endgenerate
endmodule

// File: tb/fetch_group_former_test.sv
module fetch_group_former_test;
    localparam int AW = 32, LB = 32, FW = 4, SW = 16, CNTW = 16;
    localparam int WORDS = LB / 4;
    localparam int OFFW  = $clog2(LB);
    localparam int CW    = $clog2(FW + 1);

    logic clk = 0;
    logic rst_n = 0;
    always #10 clk = ~clk;

    logic                 redir_valid = 0;
    logic [AW-1:0]        redir_pc = '0;
    logic                 fetch_req = 0;
    logic                 miss_pending = 0;
    logic [LB*8-1:0]      line_data = '0;
    logic [WORDS-1:0]     ctl_mask = '0, taken_mask = '0, quiesce_mask = '0;
    logic [WORDS*AW-1:0]  pred_target = '0;
    logic                 grp_valid;
    logic [CW-1:0]        grp_count;
    logic [FW-1:0]        slot_valid;
    logic [FW*32-1:0]     slot_insn;
    logic [FW*AW-1:0]     slot_pc;
    logic [FW*SW-1:0]     slot_seq;
    logic [AW-1:0]        fetch_pc;
    logic                 quiesce_pending, dslot_pending;
    logic [CNTW-1:0]      cnt_fetched, cnt_branch, cnt_taken, cnt_stall;

    fetch_group_former #(.AW(AW), .LINE_BYTES(LB), .FETCH_W(FW), .SEQ_W(SW),
                         .CNT_W(CNTW), .DELAY_SLOT(1), .RESET_PC('0)) uut (.*);

    typedef struct {
        logic               v;
        int                 cnt;
        logic [FW-1:0]      mask;
        logic [FW*AW-1:0]   pc;
        logic [FW*32-1:0]   ins;
        logic [FW*SW-1:0]   sq;
        logic [AW-1:0]      fpc;
        logic               qp, dsp;
        int                 fet, br, tk, st;
        string              rq;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, fails = 0;
    bit done = 0;

    // reference state
    logic [AW-1:0] m_pc = '0, m_dst = '0;
    int  m_seq = 0, m_fet = 0, m_br = 0, m_tk = 0, m_st = 0;
    bit  m_dsp = 0, m_q = 0;

    function automatic logic [31:0] word_of(int tag, int w);
        return 32'hA500_0000 + 32'(tag * 256 + w);
    endfunction
    function automatic logic [AW-1:0] tgt_of(int tag, int w);
        return AW'(32'h0000_4000 + tag * 256 + w * 4);
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic step(bit rv, logic [AW-1:0] rpc, bit rq_, bit miss,
                        logic [WORDS-1:0] ctl, logic [WORDS-1:0] tk,
                        logic [WORDS-1:0] qu, int tag, string rq);
        exp_t e;
        bit stop;
        logic [AW-1:0] cur;
        int w;
        @(negedge clk);
        redir_valid = rv; redir_pc = rpc; fetch_req = rq_; miss_pending = miss;
        ctl_mask = ctl; taken_mask = tk; quiesce_mask = qu;
        for (int i = 0; i < WORDS; i++) begin
            line_data[i*32 +: 32]   = word_of(tag, i);
            pred_target[i*AW +: AW] = tgt_of(tag, i);
        end
        e.v = 0; e.cnt = 0; e.mask = '0; e.pc = '0; e.ins = '0; e.sq = '0; e.rq = rq;
        if (rv) begin
            m_pc = rpc; m_dsp = 0; m_q = 0;
        end else if (rq_ && !m_q) begin
            if (miss) m_st++;
            else begin
                stop = 0; cur = m_pc; w = int'(m_pc[OFFW-1:2]);
                for (int k = 0; k < FW; k++) begin
                    if (!stop && w < WORDS) begin
                        e.mask[k] = 1; e.pc[k*AW +: AW] = cur;
                        e.ins[k*32 +: 32] = word_of(tag, w);
                        e.sq[k*SW +: SW] = SW'(m_seq + k);
                        e.cnt++;
                        if (m_dsp) begin cur = m_dst; m_dsp = 0; stop = 1; end
                        else if (ctl[w]) begin
                            m_br++;
                            if (tk[w]) begin m_tk++; m_dsp = 1; m_dst = tgt_of(tag, w); cur = cur + 4; end
                            else cur = cur + 4;
                        end else cur = cur + 4;
                        if (qu[w]) begin m_q = 1; stop = 1; end
                        w++;
                    end
                end
                m_pc = cur; m_seq += e.cnt; m_fet += e.cnt; e.v = e.cnt > 0;
            end
        end
        e.fpc = m_pc; e.qp = m_q; e.dsp = m_dsp;
        e.fet = m_fet; e.br = m_br; e.tk = m_tk; e.st = m_st;
        #1 exp_q.push_back(e);
    endtask

    // monitor: each queued entry is due one clock after its stimulus
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(grp_valid == e.v, e.rq, "R10 grp_valid", grp_valid, e.v);
            chk(grp_count == CW'(e.cnt), e.rq, "R10 grp_count", grp_count, e.cnt);
            chk(slot_valid == e.mask, e.rq, "R3 slot_valid", slot_valid, e.mask);
            chk(slot_pc == e.pc, e.rq, "R2 slot_pc", slot_pc, e.pc);
            chk(slot_insn == e.ins, e.rq, "R2 slot_insn", slot_insn, e.ins);
            chk(slot_seq == e.sq, e.rq, "R4 slot_seq", slot_seq, e.sq);
            chk(fetch_pc == e.fpc, e.rq, "fetch_pc", fetch_pc, e.fpc);
            chk(quiesce_pending == e.qp, e.rq, "R8 quiesce_pending", quiesce_pending, e.qp);
            chk(dslot_pending == e.dsp, e.rq, "R6 dslot_pending", dslot_pending, e.dsp);
            chk(cnt_fetched == CNTW'(e.fet), e.rq, "R7 cnt_fetched", cnt_fetched, e.fet);
            chk(cnt_branch == CNTW'(e.br), e.rq, "R7 cnt_branch", cnt_branch, e.br);
            chk(cnt_taken == CNTW'(e.tk), e.rq, "R7 cnt_taken", cnt_taken, e.tk);
            chk(cnt_stall == CNTW'(e.st), e.rq, "R9 cnt_stall", cnt_stall, e.st);
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(grp_valid == 0 && slot_valid == 0, "R1", "group after reset", slot_valid, 0);
        chk(slot_pc == 0 && slot_insn == 0 && slot_seq == 0, "R1", "slots after reset", slot_pc, 0);
        chk(fetch_pc == 0 && !quiesce_pending && !dslot_pending, "R1", "pc/flags", fetch_pc, 0);
        chk(cnt_fetched == 0 && cnt_branch == 0 && cnt_taken == 0 && cnt_stall == 0,
            "R1", "counters", cnt_fetched, 0);

        step(1, 32'h100, 0, 0, '0, '0, '0, 1, "R11");          // redirect
        step(0, '0, 1, 0, '0, '0, '0, 2, "R2");                  // aligned, width limit
        step(0, '0, 1, 0, '0, '0, '0, 3, "R3");                  // words 4..7
        step(1, 32'h118, 0, 0, '0, '0, '0, 4, "R11");
        step(0, '0, 1, 0, '0, '0, '0, 5, "R3");                  // line end after 2
        step(1, 32'h140, 0, 0, '0, '0, '0, 6, "R11");
        step(0, '0, 1, 0, 8'b0000_0110, 8'b0000_0110, '0, 7, "R5"); // taken + ignored ds bits
        step(1, 32'h15C, 0, 0, '0, '0, '0, 8, "R11");
        step(0, '0, 1, 0, 8'b1000_0000, 8'b1000_0000, '0, 9, "R6"); // ds carried
        step(0, '0, 1, 0, 8'b0000_0001, 8'b0000_0001, '0, 10, "R6"); // ds only
        step(1, 32'h180, 0, 0, '0, '0, '0, 11, "R11");
        step(0, '0, 1, 0, 8'b0000_0001, '0, '0, 12, "R7");        // not-taken
        step(0, '0, 1, 1, '0, '0, '0, 13, "R9");                  // miss
        step(0, '0, 1, 1, '0, '0, '0, 14, "R9");
        step(0, '0, 0, 0, 8'hFF, 8'hFF, 8'hFF, 15, "R12");        // idle
        step(1, 32'h1A0, 0, 0, '0, '0, '0, 16, "R11");
        step(0, '0, 1, 0, '0, '0, 8'b0000_0010, 17, "R8");       // quiesce
        step(0, '0, 1, 0, '0, '0, '0, 18, "R8");                  // parked
        step(0, '0, 1, 1, '0, '0, '0, 19, "R8");                  // parked, no stall
        step(1, 32'h1C0, 0, 0, '0, '0, '0, 20, "R11");
        step(0, '0, 1, 0, '0, '0, '0, 21, "R4");
        step(1, 32'h1DC, 0, 0, '0, '0, '0, 22, "R11");
        step(0, '0, 1, 0, 8'b1000_0000, 8'b1000_0000, '0, 23, "R6");
        step(1, 32'h200, 1, 0, '0, '0, '0, 24, "R11");            // redirect wins, clears ds
        step(0, '0, 1, 0, '0, '0, '0, 25, "R11");
        step(0, '0, 0, 0, '0, '0, '0, 26, "R12");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule